// File: doc/BRIEF.md
# Reset-on-Read Error Counter Bank

This block holds four 16-bit event counters for a line or framer receiver: one each for excessive-zero events, line code violations, framing bit/byte errors and parity errors. Each counter advances by one for every cycle its one-cycle event strobe is high and stops at its ceiling instead of wrapping.

A host with an 8-bit data path reads each counter as two byte addresses, one per byte. The first byte read of a counter may target either byte. In one cycle it returns that byte, clears the whole counter, and parks the other byte in a holding register that all counters share. The host then reads the holding register to finish the 16-bit value. Because the snapshot and the clear happen in the same cycle, no event falls between the two halves, and an event that arrives in the clearing cycle is kept as the new count of one.

Top module: `err_ctr_bank`

## Requirements
- R1: A synchronous active-high reset sets all counters, the holding register and rdata to zero.
- R2: Each cycle that a counter's event strobe `ev_i[k]` is high (and no clearing read targets it), that counter increments by one.
- R3: A counter at 0xFFFF stays at 0xFFFF when further events arrive.
- R4: With rd_en high, address 2k returns the low byte and address 2k+1 returns the high byte of counter k (k = 0..3), on rdata in the cycle after rd_en.
- R5: A read of either byte of counter k clears the whole 16-bit counter to zero.
- R6: That read copies the byte that was not read into the shared holding register, and a read of address 8 returns the holding register's value.
- R7: If counter k's event strobe is high in the same cycle as a clearing read of counter k, the counter becomes 1.
- R8: Reading address 8 changes neither any counter nor the holding register.
- R9: Reads of addresses 9 to 15 return zero and change neither any counter nor the holding register.
- R10: While rd_en is low, rdata keeps its last value.
- R11: A read of one counter has no effect on the count of any other counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ev_i | input | 4 | Event strobes, one bit per counter (0 excessive zeros, 1 line code violations, 2 framing errors, 3 parity errors) |
| rd_en | input | 1 | Read strobe for one byte |
| addr | input | 4 | Byte address: 2k low byte, 2k+1 high byte of counter k, 8 holding register |
| rdata | output | 8 | Registered read data, valid the cycle after rd_en |

## Verification
The bench drives a counter all the way to its ceiling and reads it back. A design that wraps would return a small value instead of 0xFF in both bytes. It places an event in the same cycle as a clearing read, which a design that drops that event would report as zero on the next read. It reads the holding register twice and reads from unmapped addresses, so a design that clears or reloads the holding register on those reads returns a different byte. Random traffic mixes events on all counters with reads of every address, so a snapshot taken from the wrong counter or the wrong byte lane, or a clear that spills onto a neighbouring counter, shows up as a mismatch against the bench's model.

// File: rtl/err_ctr_pkg.sv
package err_ctr_pkg;

    localparam int unsigned N_CTRS    = 4;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned CTR_W     = 2 * BYTE_W;
    localparam int unsigned IDX_W     = $clog2(N_CTRS);
    localparam int unsigned ADDR_W    = IDX_W + 2;
    localparam int unsigned HOLD_ADDR = 2 * N_CTRS;

    typedef logic [CTR_W-1:0]  ctr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam ctr_t CTR_MAX = '1;

    typedef enum logic {
        LANE_LSB = 1'b0,
        LANE_MSB = 1'b1
    } lane_e;

    typedef struct packed {
        logic             hit_ctr;
        logic             hit_hold;
        logic [IDX_W-1:0] idx;
        lane_e            lane;
    } rd_req_t;

    function automatic ctr_t sat_inc(input ctr_t c);
        return (c == CTR_MAX) ? c : ctr_t'(c + 1'b1);
    endfunction

    function automatic byte_t pick_byte(input ctr_t c, input lane_e l);
        return (l == LANE_MSB) ? c[CTR_W-1:BYTE_W] : c[BYTE_W-1:0];
    endfunction

    function automatic lane_e flip_lane(input lane_e l);
        return (l == LANE_MSB) ? LANE_LSB : LANE_MSB;
    endfunction

endpackage

// File: rtl/err_rd_decode.sv
module err_rd_decode
    import err_ctr_pkg::*;
#(
    parameter int unsigned NUM_CTRS = N_CTRS
) (
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    output rd_req_t             req,
    output logic [NUM_CTRS-1:0] clr
);

    always_comb begin
        req = '0;
        clr = '0;
        if (rd_en) begin
            if (addr < ADDR_W'(HOLD_ADDR)) begin
                req.hit_ctr = 1'b1;
                req.idx     = addr[IDX_W:1];
                req.lane    = lane_e'(addr[0]);
                for (int k = 0; k < NUM_CTRS; k++) begin
                    if (addr[IDX_W:1] == IDX_W'(k)) begin
                        clr[k] = 1'b1;
                    end
                end
            end else if (addr == ADDR_W'(HOLD_ADDR)) begin
                req.hit_hold = 1'b1;
            end
        end
    end

endmodule

// File: rtl/err_sat_ctr.sv
module err_sat_ctr
    import err_ctr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ev,
    input  logic clr,
    output ctr_t cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= ev ? ctr_t'(1) : '0;
        end else if (ev) begin
            cnt <= sat_inc(cnt);
        end
    end

endmodule

// File: rtl/err_snap_mux.sv
module err_snap_mux
    import err_ctr_pkg::*;
#(
    parameter int unsigned NUM_CTRS = N_CTRS
) (
    input  ctr_t [NUM_CTRS-1:0] cnt_all,
    input  rd_req_t             req,
    output byte_t               rd_byte,
    output byte_t               keep_byte
);

    ctr_t sel_cnt;

    always_comb begin
        sel_cnt   = cnt_all[req.idx];
        rd_byte   = pick_byte(sel_cnt, req.lane);
        keep_byte = pick_byte(sel_cnt, flip_lane(req.lane));
    end

endmodule

// File: rtl/err_ctr_bank.sv
module err_ctr_bank
    import err_ctr_pkg::*;
#(
    parameter int unsigned NUM_CTRS = N_CTRS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_CTRS-1:0] ev_i,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    output logic [BYTE_W-1:0]   rdata
);

    ctr_t [NUM_CTRS-1:0] cnt_q;
    logic [NUM_CTRS-1:0] clr;
    rd_req_t             req;
    byte_t               rd_byte;
    byte_t               keep_byte;
    byte_t               hold_q;
    byte_t               rdata_q;

    err_rd_decode #(.NUM_CTRS(NUM_CTRS)) u_decode (
        .rd_en (rd_en),
        .addr  (addr),
        .req   (req),
        .clr   (clr)
    );

    for (genvar k = 0; k < NUM_CTRS; k++) begin : g_ctr
        err_sat_ctr u_ctr (
            .clk (clk),
            .rst (rst),
            .ev  (ev_i[k]),
            .clr (clr[k]),
            .cnt (cnt_q[k])
        );
    end

    err_snap_mux #(.NUM_CTRS(NUM_CTRS)) u_mux (
        .cnt_all   (cnt_q),
        .req       (req),
        .rd_byte   (rd_byte),
        .keep_byte (keep_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            rdata_q <= '0;
        end else if (req.hit_ctr) begin
            rdata_q <= rd_byte;
            hold_q  <= keep_byte;
        end else if (req.hit_hold) begin
            rdata_q <= hold_q;
        end else if (rd_en) begin
            rdata_q <= '0;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/err_ctr_bank_chk.sv
module err_ctr_bank_chk
    import err_ctr_pkg::*;
#(
    parameter int unsigned NUM_CTRS = N_CTRS
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_CTRS-1:0] ev_i,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [BYTE_W-1:0]   rdata,
    input ctr_t [NUM_CTRS-1:0] cnt,
    input byte_t               hold
);

    logic             ctr_hit;
    logic [IDX_W-1:0] hit_idx;
    byte_t            unread_byte;

    always_comb begin
        ctr_hit     = rd_en && (addr < ADDR_W'(HOLD_ADDR));
        hit_idx     = addr[IDX_W:1];
        unread_byte = addr[0] ? cnt[hit_idx][BYTE_W-1:0] : cnt[hit_idx][CTR_W-1:BYTE_W];
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (rdata == '0 && hold == '0 && cnt == '0)); // R1

    AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ctr_hit |=> (hold == $past(unread_byte))); // R6

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ctr_hit |=> $stable(hold)); // R8

    AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R10

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr > ADDR_W'(HOLD_ADDR)) |=> (rdata == '0)); // R9

    for (genvar k = 0; k < NUM_CTRS; k++) begin : g_chk
        logic clr_k;
        assign clr_k = ctr_hit && (hit_idx == IDX_W'(k));

        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            (!clr_k && cnt[k] == CTR_MAX) |=> (cnt[k] == CTR_MAX)); // R3

        AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
            (!clr_k && ev_i[k] && cnt[k] != CTR_MAX) |=> (cnt[k] == ctr_t'($past(cnt[k]) + 1'b1))); // R2

        AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
            (!clr_k && !ev_i[k]) |=> $stable(cnt[k])); // R11

        AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
            (clr_k && !ev_i[k]) |=> (cnt[k] == '0)); // R5

        AST_CLEAR_KEEPS_EVENT: assert property (@(posedge clk) disable iff (rst)
            (clr_k && ev_i[k]) |=> (cnt[k] == ctr_t'(1))); // R7
    end

endmodule

bind err_ctr_bank err_ctr_bank_chk #(.NUM_CTRS(NUM_CTRS)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .ev_i  (ev_i),
    .rd_en (rd_en),
    .addr  (addr),
    .rdata (rdata),
    .cnt   (cnt_q),
    .hold  (hold_q)
);

// File: tb/err_ctr_bank_tb.sv
module err_ctr_bank_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ev_i = '0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] rdata;

    int checks = 0;
    int errors = 0;

    int m_cnt [4];
    int m_hold;
    int m_rdata;

    always #5 clk = ~clk;

    err_ctr_bank u_dut (
        .clk   (clk),
        .rst   (rst),
        .ev_i  (ev_i),
        .rd_en (rd_en),
        .addr  (addr),
        .rdata (rdata)
    );

    task automatic check(input string tag, input int exp);
        checks++;
        if (rdata !== 8'(exp)) begin
            errors++;
            $display("FAIL %s: rdata=%02h expected %02h", tag, rdata, 8'(exp));
        end
    endtask

    task automatic model_update(input logic [3:0] ev, input logic rd, input logic [3:0] a);
        bit clr [4];
        for (int k = 0; k < 4; k++) clr[k] = 1'b0;
        if (rd) begin
            if (a < 8) begin
                int k = a / 2;
                int c = m_cnt[k];
                m_rdata = a[0] ? (c / 256) : (c % 256);
                m_hold  = a[0] ? (c % 256) : (c / 256);
                clr[k]  = 1'b1;
            end else if (a == 8) begin
                m_rdata = m_hold;
            end else begin
                m_rdata = 0;
            end
        end
        for (int k = 0; k < 4; k++) begin
            if (clr[k]) m_cnt[k] = ev[k] ? 1 : 0;
            else if (ev[k] && m_cnt[k] < 65535) m_cnt[k] = m_cnt[k] + 1;
        end
    endtask

    task automatic step(input logic [3:0] ev, input logic rd, input logic [3:0] a, input string tag);
        ev_i  = ev;
        rd_en = rd;
        addr  = a;
        @(posedge clk);
        model_update(ev, rd, a);
        @(negedge clk);
        check(tag, m_rdata);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run still active, expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) m_cnt[k] = 0;
        m_hold  = 0;
        m_rdata = 0;

        // R1: reset state
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 0);
        rst = 1'b0;
        step(4'b0000, 1'b1, 4'd8, "R1");

        // R2, R4, R6, R5: low byte first on counter 0
        for (int i = 0; i < 5; i++) step(4'b0001, 1'b0, 4'd0, "R2");
        step(4'b0000, 1'b1, 4'd0, "R4");
        step(4'b0000, 1'b1, 4'd8, "R6");
        step(4'b0000, 1'b1, 4'd0, "R5");

        // R4, R6, R8, R5: high byte first on counter 1 (300 = 0x012C)
        for (int i = 0; i < 300; i++) step(4'b0010, 1'b0, 4'd0, "R2");
        step(4'b0000, 1'b1, 4'd3, "R4");
        step(4'b0000, 1'b1, 4'd8, "R6");
        step(4'b0000, 1'b1, 4'd8, "R8");
        step(4'b0000, 1'b1, 4'd2, "R5");

        // R7: event in the clearing cycle
        for (int i = 0; i < 3; i++) step(4'b0100, 1'b0, 4'd0, "R2");
        step(4'b0100, 1'b1, 4'd4, "R7");
        step(4'b0000, 1'b1, 4'd4, "R7");

        // R11: reads of counter 0 leave counter 3 counting
        for (int i = 0; i < 10; i++) step(4'b1000, 1'b1, 4'd0, "R11");
        step(4'b0000, 1'b1, 4'd6, "R11");

        // R9: unmapped reads return zero and leave the holding register
        step(4'b0000, 1'b1, 4'd12, "R9");
        step(4'b0000, 1'b1, 4'd15, "R9");
        step(4'b0000, 1'b1, 4'd8, "R9");

        // R10: rdata holds while rd_en is low
        step(4'b0000, 1'b0, 4'd3, "R10");
        step(4'b1111, 1'b0, 4'd8, "R10");

        // R3: drive counter 0 past the ceiling
        for (int i = 0; i < 70000; i++) step(4'b0001, 1'b0, 4'd0, "R3");
        step(4'b0000, 1'b1, 4'd1, "R3");
        step(4'b0000, 1'b1, 4'd8, "R3");

        // R11: random mix of events and reads on every address
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] ev = 4'($urandom_range(0, 15));
            logic       rd = ($urandom_range(0, 3) != 0);
            logic [3:0] a  = 4'($urandom_range(0, 15));
            step(ev, rd, a, "R11");
        end

        summary();
        $finish;
    end

endmodule